// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Condition Flags

This block is the data-processing stage of a 32-bit integer core. It takes the first-operand register value and an already-shifted second operand, performs one of six arithmetic operations (add, add with carry, subtract, reverse subtract, and the carry-chained forms of both subtracts) or one of two bitwise operations (AND, exclusive OR), and works out the next negative, zero, carry and overflow flags. The result and the next flags are combinational. The carry flag after a subtraction means "no borrow".

A flag register inside the block holds the current flags. The arithmetic uses them as carry-in, and they are written back on every valid instruction. Flags change only when the instruction asks for it. An instruction that sets flags, writes the program counter and runs in a mode with a saved status register does not update the flags. It raises a request to restore the status word from the saved copy, and the logic around the block carries out that restore.

Top module: `dp_alu`

## Requirements
- R1: With op_i = 0 the result is rn_i + op2_i. With op_i = 1 it is rn_i + op2_i + C, where C is the held carry flag (flags_o bit 1).
- R2: With op_i = 2 the result is rn_i − op2_i. With op_i = 4 it is op2_i − rn_i. All results wrap modulo 2^32.
- R3: With op_i = 3 the result is rn_i − op2_i − (1 − C). With op_i = 5 it is op2_i − rn_i − (1 − C).
- R4: When flags are updated, N (flags bit 3) equals result bit 31 and Z (flags bit 2) is 1 exactly when the result is zero.
- R5: For op_i 0 and 1, C (bit 1) is the carry out of bit 31 of the full sum, including the carry-in.
- R6: For op_i 2 to 5, C is 1 when the minuend is at least the subtrahend plus the borrow-in, compared unsigned. C therefore means no borrow.
- R7: V (bit 0) is 1 for an add when both operands share a sign and the result's sign differs from it. For a subtract, V is 1 when the operand signs differ and the result's sign differs from the minuend's.
- R8: op_i = 6 gives rn_i AND op2_i and op_i = 7 gives rn_i XOR op2_i. For these two, C takes shift_carry_i and V is left unchanged.
- R9: With set_flags_i low, next_flags_o equals the held flags.
- R10: restore_o is 1 exactly when set_flags_i, dst_pc_i and has_saved_i are all high. While it is 1 the flags are left unchanged. A write to the program counter with has_saved_i low updates the flags normally.
- R11: The held flags reset to zero and take next_flags_o on a rising clock edge only when valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction valid; loads the flag register |
| op_i | input | 3 | Operation code (0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 RSB, 5 RSC, 6 AND, 7 EOR) |
| set_flags_i | input | 1 | The instruction updates the flags |
| dst_pc_i | input | 1 | Destination register is the program counter |
| has_saved_i | input | 1 | Current mode has a saved status register |
| rn_i | input | 32 | First operand |
| op2_i | input | 32 | Shifted second operand |
| shift_carry_i | input | 1 | Carry out of the shifter |
| result_o | output | 32 | Operation result |
| next_flags_o | output | 4 | Next flags {N,Z,C,V} |
| restore_o | output | 1 | Request to restore status from the saved copy |
| flags_o | output | 4 | Held flags {N,Z,C,V} |

## Verification
The assertions run on every cycle and check the properties that hold structurally. The flags stay put when set_flags_i is low or a restore is requested. A restore is raised only when its three conditions all hold. Z agrees with the result. V survives a bitwise operation. The register holds its value without a valid strobe and loads the computed value with one. Only the bench scenarios can show the arithmetic values: wrap-around sums, carry and borrow at the unsigned boundary, signed overflow at the sign boundary, and the carry-in and borrow-in of the chained forms, which need the held carry to be set by an earlier instruction.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_RSB = 3'd4,
    OP_RSC = 3'd5,
    OP_AND = 3'd6,
    OP_EOR = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic is_logic_op(alu_op_e op);
    return (op == OP_AND) || (op == OP_EOR);
  endfunction
endpackage

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] op2_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o
);
  logic         rev, sub, cin;
  logic [W-1:0] x, y;
  logic [W:0]   sum;

  always_comb begin
    rev = (op_i == OP_RSB) || (op_i == OP_RSC);
    sub = (op_i == OP_SUB) || (op_i == OP_SBC) || rev;
    unique case (op_i)
      OP_ADC:                cin = c_i;
      OP_SUB, OP_RSB:        cin = 1'b1;
      OP_SBC, OP_RSC:        cin = c_i;  // a + ~b + C == a - b - !C
      default:               cin = 1'b0;
    endcase
    x   = rev ? op2_i : rn_i;
    y   = rev ? rn_i : op2_i;
    if (sub) y = ~y;
    sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  end

  assign res_o = sum[W-1:0];
  assign c_o   = sum[W];  // carry out; for subtracts equals no-borrow
  assign v_o   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] op2_i,
  output logic [W-1:0] res_o
);
  assign res_o = (op_i == OP_AND) ? (rn_i & op2_i) : (rn_i ^ op2_i);
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic         set_flags_i,
  input  logic         dst_pc_i,
  input  logic         has_saved_i,
  input  nzcv_t        cur_i,
  input  logic [W-1:0] res_i,
  input  logic         arith_c_i,
  input  logic         arith_v_i,
  input  logic         shift_carry_i,
  output nzcv_t        next_o,
  output logic         restore_o
);
  logic logic_op;

  always_comb begin
    logic_op  = is_logic_op(op_i);
    restore_o = set_flags_i && dst_pc_i && has_saved_i;
    next_o    = cur_i;
    if (set_flags_i && !restore_o) begin
      next_o.n = res_i[W-1];
      next_o.z = ~|res_i;
      next_o.c = logic_op ? shift_carry_i : arith_c_i;
      next_o.v = logic_op ? cur_i.v : arith_v_i;
    end
  end
endmodule

// File: rtl/dp_flag_reg.sv
module dp_flag_reg
  import dp_alu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  nzcv_t d_i,
  output nzcv_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (valid_i) q_o <= d_i;
  end

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(q_o));
  a_r11_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [2:0]   op_i,
  input  logic         set_flags_i,
  input  logic         dst_pc_i,
  input  logic         has_saved_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] op2_i,
  input  logic         shift_carry_i,
  output logic [W-1:0] result_o,
  output logic [3:0]   next_flags_o,
  output logic         restore_o,
  output logic [3:0]   flags_o
);
  alu_op_e      op;
  nzcv_t        cur, nxt;
  logic [W-1:0] arith_res, logic_res;
  logic         arith_c, arith_v;

  assign op = alu_op_e'(op_i);

  dp_alu_arith #(.W(W)) u_arith (
    .op_i (op), .rn_i (rn_i), .op2_i (op2_i), .c_i (cur.c),
    .res_o(arith_res), .c_o (arith_c), .v_o (arith_v)
  );

  dp_alu_logic #(.W(W)) u_logic (
    .op_i (op), .rn_i (rn_i), .op2_i (op2_i), .res_o (logic_res)
  );

  assign result_o = is_logic_op(op) ? logic_res : arith_res;

  dp_alu_flags #(.W(W)) u_flags (
    .op_i         (op),
    .set_flags_i  (set_flags_i),
    .dst_pc_i     (dst_pc_i),
    .has_saved_i  (has_saved_i),
    .cur_i        (cur),
    .res_i        (result_o),
    .arith_c_i    (arith_c),
    .arith_v_i    (arith_v),
    .shift_carry_i(shift_carry_i),
    .next_o       (nxt),
    .restore_o    (restore_o)
  );

  dp_flag_reg u_reg (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i), .d_i (nxt), .q_o (cur)
  );

  assign next_flags_o = nxt;
  assign flags_o      = cur;

  a_r9_no_set_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_flags_i |-> (next_flags_o == flags_o));
  a_r10_restore_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (next_flags_o == flags_o));
  a_r10_restore_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (set_flags_i && dst_pc_i && has_saved_i));
  a_r4_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && !restore_o) |-> (next_flags_o[2] == (result_o == '0)));
  a_r8_logic_v_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && !restore_o && op_i[2] && op_i[1]) |-> (next_flags_o[0] == flags_o[0]));
endmodule

// File: tb/tb_dp_alu.sv
module tb_dp_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic        sf = 1'b0, pc = 1'b0, hs = 1'b0, sc = 1'b0;
  logic [31:0] rn = '0, op2 = '0;
  logic [31:0] result;
  logic [3:0]  nflags, flags;
  logic        restore;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  nf;
    logic        rst;
    logic [3:0]  cur;
    string       tag;
  } item_t;

  item_t sbq[$];
  event  ev_chk;
  logic [3:0] mflags = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dp_alu dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .set_flags_i(sf), .dst_pc_i(pc), .has_saved_i(hs),
    .rn_i(rn), .op2_i(op2), .shift_carry_i(sc),
    .result_o(result), .next_flags_o(nflags), .restore_o(restore), .flags_o(flags)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference: wide signed/unsigned integer arithmetic
  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic s_c, input logic s_f, input logic p, input logic h,
                       input logic v, input string tag);
    item_t it;
    longint ua, ub, ur;
    longint sa, sb, sr;
    logic   c_flag, cin, borrow, carry, ovf;
    logic [31:0] r;
    @(negedge clk);
    op = o; rn = a; op2 = b; sc = s_c; sf = s_f; pc = p; hs = h; valid = v;
    c_flag = mflags[1];
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    carry = 1'b0; ovf = 1'b0;
    if (o == 3'd4 || o == 3'd5) begin
      ua = longint'(b); ub = longint'(a);
      sa = longint'($signed(b)); sb = longint'($signed(a));
    end
    case (o)
      3'd0, 3'd1: begin
        cin = (o == 3'd1) ? c_flag : 1'b0;
        ur = ua + ub + longint'(cin);
        sr = sa + sb + longint'(cin);
        r = ur[31:0];
        carry = ur > 64'sd4294967295;
        ovf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'd2, 3'd3, 3'd4, 3'd5: begin
        borrow = (o == 3'd3 || o == 3'd5) ? !c_flag : 1'b0;
        ur = ua - ub - longint'(borrow);
        sr = sa - sb - longint'(borrow);
        r = ur[31:0];
        carry = ua >= ub + longint'(borrow);
        ovf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'd6: r = a & b;
      default: r = a ^ b;
    endcase
    it.res = r;
    it.rst = s_f && p && h;
    it.cur = mflags;
    it.nf  = mflags;
    if (s_f && !it.rst) begin
      it.nf[3] = r[31];
      it.nf[2] = (r == 32'd0);
      it.nf[1] = (o >= 3'd6) ? s_c : carry;
      it.nf[0] = (o >= 3'd6) ? mflags[0] : ovf;
    end
    it.tag = tag;
    sbq.push_back(it);
    ->ev_chk;
    if (v) mflags = it.nf;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(ev_chk);
      #1;
      it = sbq.pop_front();
      check(it.tag, "result", result, it.res);
      check(it.tag, "next_flags", {28'd0, nflags}, {28'd0, it.nf});
      check(it.tag, "restore", {31'd0, restore}, {31'd0, it.rst});
      check("R11", "held_flags", {28'd0, flags}, {28'd0, it.cur});
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    check("R11", "reset_flags", {28'd0, flags}, 32'd0);
    rst_n = 1'b1;
    // R1 / R4 / R5 / R7
    issue(3'd0, 32'd1, 32'd2, 0, 1, 0, 0, 1, "R1");
    issue(3'd0, 32'hFFFF_FFFF, 32'd1, 0, 1, 0, 0, 1, "R5");      // Z,C
    issue(3'd1, 32'd10, 32'd20, 0, 1, 0, 0, 1, "R1");            // C=1 in
    issue(3'd0, 32'h7FFF_FFFF, 32'd1, 0, 1, 0, 0, 1, "R7");      // N,V
    issue(3'd0, 32'h8000_0000, 32'h8000_0000, 0, 1, 0, 0, 1, "R7");
    issue(3'd1, 32'hFFFF_FFFF, 32'd0, 0, 1, 0, 0, 1, "R5");      // carry-in gives carry
    issue(3'd1, 32'h7FFF_FFFF, 32'd0, 0, 1, 0, 0, 1, "R7");      // carry-in gives overflow
    // R2 / R6
    issue(3'd2, 32'd5, 32'd5, 0, 1, 0, 0, 1, "R6");              // Z, C=1
    issue(3'd2, 32'd3, 32'd5, 0, 1, 0, 0, 1, "R6");              // borrow, N
    issue(3'd4, 32'd3, 32'd5, 0, 1, 0, 0, 1, "R2");
    issue(3'd2, 32'h8000_0000, 32'd1, 0, 1, 0, 0, 1, "R7");
    issue(3'd4, 32'd1, 32'h8000_0000, 0, 1, 0, 0, 1, "R7");
    // R3 with C clear then set
    issue(3'd2, 32'd0, 32'd1, 0, 1, 0, 0, 1, "R6");              // C=0
    issue(3'd3, 32'd0, 32'd0, 0, 1, 0, 0, 1, "R3");              // 0-0-1 borrow
    issue(3'd5, 32'd9, 32'd4, 0, 1, 0, 0, 1, "R3");
    issue(3'd2, 32'd7, 32'd7, 0, 1, 0, 0, 1, "R6");              // C=1
    issue(3'd3, 32'd7, 32'd7, 0, 1, 0, 0, 1, "R3");
    issue(3'd2, 32'd7, 32'd7, 0, 1, 0, 0, 1, "R6");
    issue(3'd5, 32'd2, 32'd9, 0, 1, 0, 0, 1, "R3");
    // R8
    issue(3'd0, 32'h7FFF_FFFF, 32'd1, 0, 1, 0, 0, 1, "R7");      // V=1
    issue(3'd6, 32'hF0F0_1234, 32'hFF00_FFFF, 1, 1, 0, 0, 1, "R8");
    issue(3'd7, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 1, 0, 0, 1, "R8");
    // R9
    issue(3'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 1, "R9");
    issue(3'd2, 32'd1, 32'd2, 0, 0, 1, 1, 1, "R9");
    // R10
    issue(3'd2, 32'd4, 32'd4, 0, 1, 1, 1, 1, "R10");
    issue(3'd2, 32'd4, 32'd4, 0, 1, 1, 0, 1, "R10");
    issue(3'd6, 32'd0, 32'd0, 1, 1, 0, 1, 1, "R10");
    // R11 valid low: flags held
    issue(3'd2, 32'd1, 32'd2, 0, 1, 0, 0, 0, "R11");
    issue(3'd0, 32'd0, 32'd0, 0, 1, 0, 0, 0, "R11");
    issue(3'd0, 32'd3, 32'd4, 0, 1, 0, 0, 1, "R11");
    issue(3'd0, 32'd0, 32'd0, 0, 0, 0, 0, 0, "R11");
    @(negedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule